// File: doc/BRIEF.md
# Burst Write Master with Ready-Latency Data Port

This block turns simple write requests (a beat-aligned start address and a byte count) into incrementing memory-mapped write bursts. It drives the address, data and response channels of an AXI4 write port. Payload beats come from a valid/ready stream and are passed straight to the data channel. Each request is cut into bursts so that no burst carries more than 512 bytes or crosses a 4 KB page. Every burst takes a transaction ID from a small pool. That ID goes back to the pool when the matching write response arrives.

The data channel uses a ready-latency rule in place of a plain valid/ready handshake. The master may keep sending beats for a fixed window after the receiver drops ready. The window length depends on the data width: 8192 divided by the width in bits, so 64 cycles at 128 bits and 8 cycles at 1024 bits. A beat counts as transferred whenever `w_valid` is high, so the receiver must hold enough buffer space to absorb the whole window. A write response with any code other than OKAY sets a sticky error flag.

Top module: `axi_burst_writer`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `aw_valid` and `w_valid` are 0, `wr_err` is 0, and `b_ready` is 1.
- R2: Every address phase drives `aw_burst` = 2'b01 (incrementing), `aw_size` = log2(DATA_W/8), and `aw_lock` = 0. Every data beat drives all bits of `w_strb` to 1.
- R3: A request at address A for N bytes is issued as consecutive bursts. Each burst starts where the previous one ended. Each burst has min(remaining beats, 512/(DATA_W/8), beats left before the next 4 KB boundary) beats, and `aw_len` is that count minus one. The bursts together cover exactly N bytes.
- R4: Each burst sends exactly `aw_len`+1 beats. Only the final beat has `w_last` = 1. Data beats leave in the order the source presented them, and none is dropped.
- R5: The master raises `w_valid` only in a cycle where `w_ready` is 1, or where `w_ready` was last 1 no more than READY_LAT cycles earlier. Before `w_ready` has ever been 1 after reset, no beat is sent. A beat is transferred whenever `w_valid` is 1.
- R6: At most MAX_OUT (4) bursts are outstanding, counted from the address handshake to the response handshake. `aw_id` is in 0..MAX_OUT-1 and never equals the ID of a burst still outstanding. While the pool is empty, `aw_valid` stays 0.
- R7: `b_ready` is held at 1. A response handshake returns the ID named by `b_id` to the pool, so issuing can resume.
- R8: A response with `b_resp` not equal to 2'b00 sets `wr_err`. The flag stays 1 until reset. The ID of that response is still released.
- R9: `req_ready` drops in the cycle after a request is accepted. It rises again once every burst of that request has completed its address and data phases, without waiting for the responses.
- R10: READY_LAT equals 8192/DATA_W (32 cycles at 256 bits). After a single-cycle `w_ready` pulse, more beats than one maximum-size burst can be sent, but never more than READY_LAT+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Master idle, request accepted on this cycle's edge |
| req_addr | input | ADDR_W | Start address, aligned to DATA_W/8 bytes |
| req_bytes | input | LEN_W | Byte count, a nonzero multiple of DATA_W/8 |
| src_valid | input | 1 | Payload beat present |
| src_ready | output | 1 | Payload beat taken |
| src_data | input | DATA_W | Payload beat |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address accepted |
| aw_id | output | ID_W | Transaction ID |
| aw_addr | output | ADDR_W | Burst start address |
| aw_len | output | 8 | Beats in burst minus one |
| aw_size | output | 3 | log2 of bytes per beat |
| aw_burst | output | 2 | Burst type, always incrementing |
| aw_lock | output | 1 | Lock, always 0 |
| w_valid | output | 1 | Data beat transferred this cycle |
| w_ready | input | 1 | Receiver space indication, ready-latency rule |
| w_data | output | DATA_W | Write data |
| w_strb | output | DATA_W/8 | Byte strobes, all set |
| w_last | output | 1 | Final beat of burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Response accepted, tied high |
| b_id | input | ID_W | ID of completed burst |
| b_resp | input | 2 | Response code, 2'b00 is OKAY |
| wr_err | output | 1 | Sticky error-response flag |

## Verification
The data-channel outputs are combinational from the source, `w_ready` and the burst state. A beat therefore shows up on `w_valid` in the same cycle the bench offers it. The address phase appears one cycle after the ID-allocation cycle. Released IDs can be reused one cycle after the response edge. `req_ready` and `wr_err` are registered and change one edge after their cause. The bench drives all inputs just after the falling edge. It waits one time unit for the combinational outputs to settle, and then records exactly the handshakes that the next rising edge will commit. Registered results are read one falling edge after the edge that produced them. The window rule is checked against the bench's own count of cycles since `w_ready` was last high.

// File: rtl/axi_burst_writer.sv
module axi_burst_writer #(
  parameter int DATA_W          = 128,
  parameter int ADDR_W          = 64,
  parameter int LEN_W           = 16,
  parameter int ID_W            = 4,
  parameter int MAX_OUT         = 4,
  parameter int MAX_BURST_BYTES = 512,
  parameter int PAGE_BYTES      = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_bytes,
  input  logic                src_valid,
  output logic                src_ready,
  input  logic [DATA_W-1:0]   src_data,
  output logic                aw_valid,
  input  logic                aw_ready,
  output logic [ID_W-1:0]     aw_id,
  output logic [ADDR_W-1:0]   aw_addr,
  output logic [7:0]          aw_len,
  output logic [2:0]          aw_size,
  output logic [1:0]          aw_burst,
  output logic                aw_lock,
  output logic                w_valid,
  input  logic                w_ready,
  output logic [DATA_W-1:0]   w_data,
  output logic [DATA_W/8-1:0] w_strb,
  output logic                w_last,
  input  logic                b_valid,
  output logic                b_ready,
  input  logic [ID_W-1:0]     b_id,
  input  logic [1:0]          b_resp,
  output logic                wr_err
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int SIZE_CODE  = $clog2(BEAT_BYTES);
  localparam int READY_LAT  = 8192 / DATA_W;
  localparam int MAX_BEATS  = MAX_BURST_BYTES / BEAT_BYTES;
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int LAT_W      = $clog2(READY_LAT + 1);
  localparam int BL_W       = $clog2(MAX_BEATS + 1);
  localparam int SLOT_W     = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RUN} state_t;

  state_t              state;
  logic [ADDR_W-1:0]   cur_addr;
  logic [LEN_W-1:0]    rem_beats;
  logic [BL_W-1:0]     blen;
  logic [BL_W-1:0]     left;
  logic                aw_pend;
  logic [SLOT_W-1:0]   cur_slot;
  logic [MAX_OUT-1:0]  busy;
  logic [LAT_W-1:0]    lat_cnt;
  logic                err_q;

  logic [PAGE_W:0]     page_room;
  logic [LEN_W-1:0]    page_beats;
  logic [LEN_W-1:0]    next_len;
  logic                free_ok;
  logic [SLOT_W-1:0]   free_slot;
  logic                win_open;
  logic                beat_go;
  logic                w_fire;
  logic                aw_done;
  logic                w_done;
  logic                burst_end;
  logic                alloc;
  logic                b_fire;
  logic [MAX_OUT-1:0]  set_mask;
  logic [MAX_OUT-1:0]  rel_mask;

  // Burst sizing: remaining beats, capped by burst limit and page room
  assign page_room  = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_W-1:0]};
  assign page_beats = LEN_W'(page_room >> SIZE_CODE);

  always_comb begin
    next_len = rem_beats;
    if (next_len > LEN_W'(MAX_BEATS)) next_len = LEN_W'(MAX_BEATS);
    if (next_len > page_beats)        next_len = page_beats;
  end

  always_comb begin
    free_ok   = 1'b0;
    free_slot = '0;
    for (int i = MAX_OUT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_ok   = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  assign win_open  = w_ready || (lat_cnt < LAT_W'(READY_LAT));
  assign beat_go   = (state == S_RUN) && (left != '0) && win_open;
  assign src_ready = beat_go;
  assign w_fire    = beat_go && src_valid;
  assign aw_done   = !aw_pend || aw_ready;
  assign w_done    = (left == '0) || ((left == BL_W'(1)) && w_fire);
  assign burst_end = (state == S_RUN) && aw_done && w_done;
  assign alloc     = (state == S_ISSUE) && free_ok;
  assign b_fire    = b_valid && (int'(b_id) < MAX_OUT);

  assign set_mask = alloc  ? ({{(MAX_OUT-1){1'b0}}, 1'b1} << free_slot) : '0;
  assign rel_mask = b_fire ? ({{(MAX_OUT-1){1'b0}}, 1'b1} << b_id[SLOT_W-1:0]) : '0;

  assign req_ready = (state == S_IDLE);
  assign aw_valid  = (state == S_RUN) && aw_pend;
  assign aw_id     = ID_W'(cur_slot);
  assign aw_addr   = cur_addr;
  assign aw_len    = 8'(blen - 1'b1);
  assign aw_size   = 3'(SIZE_CODE);
  assign aw_burst  = 2'b01;
  assign aw_lock   = 1'b0;
  assign w_valid   = w_fire;
  assign w_data    = src_data;
  assign w_strb    = '1;
  assign w_last    = (left == BL_W'(1));
  assign b_ready   = 1'b1;
  assign wr_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      rem_beats <= '0;
      blen      <= '0;
      left      <= '0;
      aw_pend   <= 1'b0;
      cur_slot  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cur_addr  <= req_addr;
          rem_beats <= LEN_W'(req_bytes >> SIZE_CODE);
          state     <= S_ISSUE;
        end
        S_ISSUE: if (free_ok) begin
          cur_slot <= free_slot;
          blen     <= BL_W'(next_len);
          left     <= BL_W'(next_len);
          aw_pend  <= 1'b1;
          state    <= S_RUN;
        end
        S_RUN: begin
          if (aw_valid && aw_ready) aw_pend <= 1'b0;
          if (w_fire) left <= left - 1'b1;
          if (burst_end) begin
            cur_addr  <= cur_addr + (ADDR_W'(blen) << SIZE_CODE);
            rem_beats <= rem_beats - LEN_W'(blen);
            state     <= (rem_beats == LEN_W'(blen)) ? S_IDLE : S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      err_q   <= 1'b0;
      lat_cnt <= LAT_W'(READY_LAT);
    end else begin
      busy <= (busy & ~rel_mask) | set_mask;
      if (b_fire && (b_resp != 2'b00)) err_q <= 1'b1;
      if (w_ready)                               lat_cnt <= '0;
      else if (lat_cnt < LAT_W'(READY_LAT))      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len) && $stable(aw_id)); // R3
  AST_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (int'(aw_len) + 1) * BEAT_BYTES <= MAX_BURST_BYTES); // R3
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> int'(aw_addr[PAGE_W-1:0]) + (int'(aw_len) + 1) * BEAT_BYTES <= PAGE_BYTES); // R3
  AST_RESP_KNOWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (int'(b_id) < MAX_OUT) && busy[b_id[SLOT_W-1:0]]); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R8
endmodule

// File: tb/test_axi_burst_writer.sv
module test_axi_burst_writer;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 256;
  localparam int BB    = DW / 8;
  localparam int RL    = 8192 / DW;
  localparam int DEPTH = 2 * RL + 2;
  localparam int NOUT  = 4;
  localparam int MAXB  = 512 / BB;
  localparam int WD_CYCLES = 150000;
  localparam int NT = 8;
  localparam logic [63:0] T_ADDR [NT] = '{64'h0, 64'h1000, 64'h2000, 64'h0FC0,
                                          64'h3F00, 64'h5020, 64'h7E00, 64'h1_0000_0FE0};
  localparam int T_BYTES [NT] = '{64, 512, 1024, 128, 1024, 32, 608, 96};
  localparam int T_NBUR  [NT] = '{1, 1, 2, 2, 3, 1, 2, 2};
  localparam int T_LEN0  [NT] = '{1, 15, 15, 1, 7, 0, 15, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [63:0] req_addr = '0;
  logic [15:0] req_bytes = '0;
  logic src_valid = 1'b0, src_ready;
  logic [DW-1:0] src_data = '0;
  logic aw_valid, aw_ready = 1'b0, aw_lock;
  logic [3:0] aw_id;
  logic [63:0] aw_addr;
  logic [7:0] aw_len;
  logic [2:0] aw_size;
  logic [1:0] aw_burst;
  logic w_valid, w_ready = 1'b0, w_last;
  logic [DW-1:0] w_data;
  logic [BB-1:0] w_strb;
  logic b_valid = 1'b0, b_ready;
  logic [3:0] b_id = '0;
  logic [1:0] b_resp = '0;
  logic wr_err;

  axi_burst_writer #(.DATA_W(DW)) i_axi_burst_writer (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_bytes,
    .src_valid, .src_ready, .src_data,
    .aw_valid, .aw_ready, .aw_id, .aw_addr, .aw_len, .aw_size, .aw_burst, .aw_lock,
    .w_valid, .w_ready, .w_data, .w_strb, .w_last,
    .b_valid, .b_ready, .b_id, .b_resp, .wr_err);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit rnd = 0, hold_b = 0;
  int rdy_mode = 0;
  int err_at = -1;
  int aw_cnt = 0, wl_cnt = 0, b_cnt = 0, chk_idx = 0, beat_in = 0;
  int src_idx = 0, rcv_idx = 0, fill = 0, gap = 1000, win_beats = 0;
  int aw_len_q [1024];
  int aw_id_q  [1024];
  int wl_beats_q [1024];
  logic [63:0] exp_addr = '0;
  int exp_rem = 0, req_bursts = 0, req_len0 = -1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Responder model: inputs driven after negedge, handshakes recorded after settle
  always begin
    @(negedge clk);
    if (!rst_n) begin
      w_ready = 0; aw_ready = 0; src_valid = 0; b_valid = 0;
    end else begin
      if (fill > 0 && (!rnd || $urandom % 2 == 0)) fill--;
      w_ready = (fill + RL + 1 <= DEPTH) &&
                ((rdy_mode == 0) ? (!rnd || $urandom % 4 != 0) : (rdy_mode == 2));
      aw_ready = !rnd || ($urandom % 3 != 0);
      src_valid = !rnd || ($urandom % 4 != 0);
      src_data = DW'(src_idx);
      if (b_cnt < aw_cnt && b_cnt < wl_cnt && !hold_b && (!rnd || $urandom % 2 == 0)) begin
        b_valid = 1; b_id = 4'(aw_id_q[b_cnt % 1024]);
        b_resp = (b_cnt == err_at) ? 2'b10 : 2'b00;
      end else b_valid = 0;
      #1;
      if (w_ready) gap = 0; else if (gap < 1000) gap++;
      if (src_valid && src_ready) src_idx++;
      if (w_valid) begin
        chk(gap <= RL, "R5", "beat outside ready window gap", gap, RL);
        if (!w_ready) win_beats++;
        fill++;
        chk(fill <= DEPTH, "R5", "receive buffer fill", fill, DEPTH);
        chk(int'(w_data[31:0]) == rcv_idx, "R4", "beat order", w_data[31:0], rcv_idx);
        chk(&w_strb, "R2", "strobe all ones", w_strb[7:0], 255);
        rcv_idx++;
        beat_in++;
        if (w_last) begin
          wl_beats_q[wl_cnt % 1024] = beat_in;
          wl_cnt++;
          beat_in = 0;
        end
      end
      if (aw_valid && aw_ready) begin
        int room, elen;
        room = (4096 - int'(exp_addr[11:0])) / BB;
        elen = exp_rem;
        if (elen > MAXB) elen = MAXB;
        if (elen > room) elen = room;
        chk(aw_burst == 2'b01, "R2", "burst type", aw_burst, 1);
        chk(aw_size == 3'd5, "R2", "size code", aw_size, 5);
        chk(aw_lock == 1'b0, "R2", "lock", aw_lock, 0);
        chk(aw_addr == exp_addr, "R3", "burst address", aw_addr, exp_addr);
        chk(int'(aw_len) + 1 == elen, "R3", "burst beats", int'(aw_len) + 1, elen);
        chk(aw_cnt - b_cnt < NOUT, "R6", "outstanding before issue", aw_cnt - b_cnt, NOUT - 1);
        chk(int'(aw_id) < NOUT, "R6", "id range", aw_id, NOUT - 1);
        for (int k = b_cnt; k < aw_cnt; k++)
          chk(aw_id_q[k % 1024] != int'(aw_id), "R6", "id reuse while outstanding", aw_id, -1);
        if (req_bursts == 0) req_len0 = int'(aw_len);
        req_bursts++;
        exp_addr = exp_addr + 64'((int'(aw_len) + 1) * BB);
        exp_rem = exp_rem - (int'(aw_len) + 1);
        aw_len_q[aw_cnt % 1024] = int'(aw_len) + 1;
        aw_id_q[aw_cnt % 1024] = int'(aw_id);
        aw_cnt++;
      end
      if (b_valid) begin
        chk(b_ready == 1'b1, "R7", "response ready", b_ready, 1);
        b_cnt++;
      end
      while (chk_idx < aw_cnt && chk_idx < wl_cnt) begin
        chk(wl_beats_q[chk_idx % 1024] == aw_len_q[chk_idx % 1024], "R4", "beats per burst (last flag)",
            wl_beats_q[chk_idx % 1024], aw_len_q[chk_idx % 1024]);
        chk_idx++;
      end
    end
  end

  task automatic start_req(input logic [63:0] a, input int nbytes);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_bytes = 16'(nbytes);
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    exp_addr = a; exp_rem = nbytes / BB; req_bursts = 0; req_len0 = -1;
    @(negedge clk);
    req_valid = 0;
    #2;
    chk(req_ready == 1'b0, "R9", "busy after accept", req_ready, 0);
  endtask

  task automatic wait_done();
    while (!req_ready) begin @(negedge clk); #2; end
    chk(exp_rem == 0, "R3", "request fully covered", exp_rem, 0);
  endtask

  task automatic wait_drain();
    while (!(b_cnt == aw_cnt && wl_cnt == aw_cnt)) begin @(negedge clk); #2; end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
      finish_run();
    end
  end

  initial begin
    int n;
    rdy_mode = 1;
    repeat (4) @(negedge clk);
    #2;
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(aw_valid == 1'b0, "R1", "aw_valid in reset", aw_valid, 0);
    chk(w_valid == 1'b0, "R1", "w_valid in reset", w_valid, 0);
    chk(wr_err == 1'b0, "R1", "wr_err in reset", wr_err, 0);
    chk(b_ready == 1'b1, "R1", "b_ready in reset", b_ready, 1);
    @(posedge clk); rst_n = 1;
    @(negedge clk); #2;
    chk(req_ready == 1'b1 && !aw_valid && !w_valid, "R1", "idle after reset", req_ready, 1);

    // Window closed since reset: no beats; then a single ready pulse
    start_req(64'h40000, 4096);
    repeat (60) @(negedge clk);
    #2;
    chk(rcv_idx == 0, "R5", "no beat before first ready", rcv_idx, 0);
    @(posedge clk); rdy_mode = 2;
    @(posedge clk); rdy_mode = 1;
    repeat (80) @(negedge clk);
    #2;
    n = rcv_idx;
    chk(n > MAXB && n <= RL + 1, "R10", "beats after one ready pulse", n, RL);
    @(posedge clk); rdy_mode = 0;
    wait_done();
    wait_drain();

    // Table of requests with randomized back-pressure
    rnd = 1;
    for (int t = 0; t < NT; t++) begin
      start_req(T_ADDR[t], T_BYTES[t]);
      wait_done();
      chk(req_bursts == T_NBUR[t], "R3", "burst count", req_bursts, T_NBUR[t]);
      chk(req_len0 == T_LEN0[t], "R3", "first aw_len", req_len0, T_LEN0[t]);
    end
    wait_drain();
    chk(wr_err == 1'b0, "R8", "no error on OKAY", wr_err, 0);

    // ID pool exhaustion and release
    rnd = 0; hold_b = 1;
    start_req(64'h20000, 4096);
    repeat (200) @(negedge clk);
    #2;
    chk(aw_cnt - b_cnt == NOUT, "R6", "outstanding at pool limit", aw_cnt - b_cnt, NOUT);
    chk(aw_valid == 1'b0, "R6", "no address with empty pool", aw_valid, 0);
    @(posedge clk); hold_b = 0;
    wait_done();
    chk(req_bursts == 8, "R7", "all bursts after release", req_bursts, 8);
    wait_drain();

    // Error response: sticky flag, ID still released
    err_at = aw_cnt;
    start_req(64'h30000, 64);
    wait_done();
    wait_drain();
    @(negedge clk); #2;
    chk(wr_err == 1'b1, "R8", "error flag set", wr_err, 1);
    hold_b = 1;
    start_req(64'h50000, 4096);
    repeat (200) @(negedge clk);
    #2;
    chk(aw_cnt - b_cnt == NOUT, "R8", "errored id released", aw_cnt - b_cnt, NOUT);
    @(posedge clk); hold_b = 0;
    wait_done();
    wait_drain();
    chk(wr_err == 1'b1, "R8", "error flag sticky", wr_err, 1);

    // Random stress
    rnd = 1;
    for (int s = 0; s < 8; s++) begin
      start_req({48'h2, 16'($urandom % 65536) & 16'hFFE0}, (1 + int'($urandom % 40)) * BB);
      wait_done();
    end
    wait_drain();
    chk(b_cnt == aw_cnt, "R7", "all responses retired", b_cnt, aw_cnt);
    chk(rcv_idx == src_idx, "R4", "no beat lost", rcv_idx, src_idx);
    chk(win_beats > 0, "R5", "beats sent while ready low", win_beats, 1);
    finish_run();
  end
endmodule